// File: doc/BRIEF.md
# Pulse-Swallow Feedback and Reference Divider

This block divides a synthesizer clock by a programmable total ratio of N×32 + A. A dual-modulus prescaler counts the input clock in periods of 33 or 32 cycles. A swallow count A selects the 33-cycle periods, and a main count N sets how many prescaler periods make up one output cycle. Each completed cycle produces one single-cycle pulse on the feedback output. A separate reference counter, with the same range as N, divides the same clock by R and pulses its own output.

The settings are sampled from plain register inputs. The feedback path takes new A and N values only when a division cycle wraps, and the reference path takes new R values only when its own cycle wraps, so no cycle ever has a mixed length. Out-of-range settings are repaired and reported on status outputs. N or R below 3 is raised to 3. A swallow count larger than the repaired N is limited to N, so that every prescaler period in the cycle runs at 33.

Top module: `pswallow_fbdiv`

## Requirements
- R1: With 0 ≤ A ≤ N and 3 ≤ N ≤ 2047, consecutive feedback pulses are exactly N×32 + A input clocks apart. Within a cycle, the first A prescaler periods last 33 clocks and the remaining N−A periods last 32.
- R2: Each feedback pulse and each reference pulse is high for exactly one input clock.
- R3: A main setting below 3 is used as 3, and `main_clamped_o` is 1 while such a setting is active (0 otherwise).
- R4: If A exceeds the repaired N, `swallow_invalid_o` is 1 while that setting is active, and the ratio becomes 33×N.
- R5: With 3 ≤ R ≤ 2047, consecutive reference pulses are exactly R input clocks apart.
- R6: A reference setting below 3 is used as 3, and `ref_clamped_o` is 1 while such a setting is active.
- R7: A, N and R changes made in the middle of a cycle do not alter the cycle in progress. They apply from the cycle that follows the next pulse of the affected output.
- R8: Synchronous active-high reset holds both pulse outputs at 0, loads the settings present at the inputs, and restarts both counts. The first feedback pulse comes N×32 + A clocks after the first clock edge without reset, and the first reference pulse comes R clocks after it. The cycle opens with 33-clock periods whenever A > 0.
- R9: The largest setting, A = 31 and N = 2047, gives a ratio of 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock being divided |
| rst_i | input | 1 | Synchronous active-high reset |
| swallow_i | input | 5 | Swallow count A |
| main_i | input | 11 | Main count N |
| ref_i | input | 11 | Reference count R |
| fb_pulse_o | output | 1 | One-clock pulse per feedback division cycle |
| ref_pulse_o | output | 1 | One-clock pulse per reference division cycle |
| main_clamped_o | output | 1 | Active N setting was raised to 3 |
| swallow_invalid_o | output | 1 | Active A setting exceeded N and was limited |
| ref_clamped_o | output | 1 | Active R setting was raised to 3 |

## Verification
The hardest case to reach from the ports is a setting change that lands in the middle of a cycle. The ports show no count state, so the only sign that the change was deferred correctly is the length of two successive pulse intervals. The bench resets with one setting, advances a known number of clocks into the cycle, and then writes a different setting. It then checks that the first interval ends at the old ratio minus the clocks already spent, and that the following interval matches the new ratio. The limiting cases (A equal to N, A above N, and N or R below 3) are reached directly through the reset-time load.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;

    localparam int A_W      = 5;
    localparam int N_W      = 11;
    localparam int R_W      = 11;
    localparam int PRESCALE = 32;
    localparam int MIN_CNT  = 3;
    localparam int PC_W     = $clog2(PRESCALE + 1);

    typedef enum logic {
        MOD_LOW  = 1'b0,   // divide by PRESCALE
        MOD_HIGH = 1'b1    // divide by PRESCALE + 1
    } modulus_e;

    typedef struct packed {
        logic [N_W-1:0] swallow;      // effective swallow count, <= main
        logic [N_W-1:0] main;         // effective main count, >= MIN_CNT
        logic           main_clamped;
        logic           swallow_bad;
    } fb_cfg_t;

    typedef struct packed {
        logic [R_W-1:0] count;
        logic           clamped;
    } ref_cfg_t;

    function automatic fb_cfg_t build_fb_cfg(input logic [A_W-1:0] a,
                                             input logic [N_W-1:0] n);
        fb_cfg_t        c;
        logic [N_W-1:0] aw;
        aw             = N_W'(a);
        c.main_clamped = (n < N_W'(MIN_CNT));
        c.main         = c.main_clamped ? N_W'(MIN_CNT) : n;
        c.swallow_bad  = (aw > c.main);
        c.swallow      = c.swallow_bad ? c.main : aw;
        return c;
    endfunction

    function automatic ref_cfg_t build_ref_cfg(input logic [R_W-1:0] r);
        ref_cfg_t c;
        c.clamped = (r < R_W'(MIN_CNT));
        c.count   = c.clamped ? R_W'(MIN_CNT) : r;
        return c;
    endfunction

endpackage

// File: rtl/pswallow_prescaler.sv
module pswallow_prescaler
    import pswallow_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    input  modulus_e mode_i,
    output logic     tick_o
);

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] final_cnt;

    assign final_cnt = (mode_i == MOD_HIGH) ? PC_W'(PRESCALE) : PC_W'(PRESCALE - 1);
    assign tick_o    = (pc_q == final_cnt);

    always_ff @(posedge clk_i) begin
        if (rst_i)       pc_q <= '0;
        else if (tick_o) pc_q <= '0;
        else             pc_q <= pc_q + 1'b1;
    end

    // R1: the count never passes the high modulus
    assert_pc_bound_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        pc_q <= PC_W'(PRESCALE));
    // R1: each period end restarts the count
    assert_pc_wrap_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_o |=> (pc_q == '0));
    // R1: the modulus is held for a whole prescaler period
    assert_mode_steady_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        !tick_o |=> $stable(mode_i));

endmodule

// File: rtl/pswallow_swallow_ctrl.sv
module pswallow_swallow_ctrl
    import pswallow_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     tick_i,
    input  fb_cfg_t  cfg_i,
    output modulus_e mode_o,
    output logic     wrap_o,
    output fb_cfg_t  act_o
);

    logic [N_W-1:0] per_q;
    fb_cfg_t        act_q;
    logic           last_period;

    assign last_period = (per_q == act_q.main - 1'b1);
    assign wrap_o      = tick_i && last_period;
    assign mode_o      = (per_q < act_q.swallow) ? MOD_HIGH : MOD_LOW;
    assign act_o       = act_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            per_q <= '0;
            act_q <= cfg_i;
        end else if (tick_i) begin
            if (last_period) begin
                per_q <= '0;
                act_q <= cfg_i;
            end else begin
                per_q <= per_q + 1'b1;
            end
        end
    end

    // R1: the period index stays inside the main count
    assert_period_bound_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        per_q < act_q.main);
    // R3: the active main count is never below the minimum
    assert_main_min_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        act_q.main >= N_W'(MIN_CNT));
    // R4: the active swallow count never exceeds the main count
    assert_swallow_le_main_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        act_q.swallow <= act_q.main);
    // R7: the settings change only at a cycle end
    assert_cfg_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        !wrap_o |=> $stable(act_q));

endmodule

// File: rtl/pswallow_ref_div.sv
module pswallow_ref_div
    import pswallow_pkg::*;
(
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic [R_W-1:0] ref_i,
    output logic           wrap_o,
    output logic           clamped_o
);

    logic [R_W-1:0] rc_q;
    ref_cfg_t       act_q;

    assign wrap_o    = (rc_q == act_q.count - 1'b1);
    assign clamped_o = act_q.clamped;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rc_q  <= '0;
            act_q <= build_ref_cfg(ref_i);
        end else if (wrap_o) begin
            rc_q  <= '0;
            act_q <= build_ref_cfg(ref_i);
        end else begin
            rc_q  <= rc_q + 1'b1;
        end
    end

    // R5: the count stays inside the active ratio
    assert_ref_bound_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        rc_q < act_q.count);
    // R6: the active reference ratio is never below the minimum
    assert_ref_min_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        act_q.count >= R_W'(MIN_CNT));
    // R7: the reference setting changes only at a cycle end
    assert_ref_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        !wrap_o |=> $stable(act_q));

endmodule

// File: rtl/pswallow_fbdiv.sv
module pswallow_fbdiv
    import pswallow_pkg::*;
(
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic [A_W-1:0] swallow_i,
    input  logic [N_W-1:0] main_i,
    input  logic [R_W-1:0] ref_i,
    output logic           fb_pulse_o,
    output logic           ref_pulse_o,
    output logic           main_clamped_o,
    output logic           swallow_invalid_o,
    output logic           ref_clamped_o
);

    modulus_e mode;
    logic     tick;
    logic     fb_wrap;
    logic     ref_wrap;
    fb_cfg_t  fb_next;
    fb_cfg_t  fb_act;

    assign fb_next = build_fb_cfg(swallow_i, main_i);

    pswallow_prescaler u_presc (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .mode_i (mode),
        .tick_o (tick)
    );

    pswallow_swallow_ctrl u_ctrl (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tick_i (tick),
        .cfg_i  (fb_next),
        .mode_o (mode),
        .wrap_o (fb_wrap),
        .act_o  (fb_act)
    );

    pswallow_ref_div u_ref (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .ref_i     (ref_i),
        .wrap_o    (ref_wrap),
        .clamped_o (ref_clamped_o)
    );

    assign main_clamped_o    = fb_act.main_clamped;
    assign swallow_invalid_o = fb_act.swallow_bad;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            fb_pulse_o  <= 1'b0;
            ref_pulse_o <= 1'b0;
        end else begin
            fb_pulse_o  <= fb_wrap;
            ref_pulse_o <= ref_wrap;
        end
    end

    // R2: pulses are one clock wide
    assert_fb_single_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        fb_pulse_o |=> !fb_pulse_o);
    assert_ref_single_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        ref_pulse_o |=> !ref_pulse_o);
    // R1: a feedback cycle ends only on a prescaler period end
    assert_wrap_on_tick_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        fb_wrap |-> tick);

endmodule

// File: tb/tb_pswallow_fbdiv.sv
`timescale 1ns/1ps
module tb_pswallow_fbdiv;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  cfg_a = '0;
    logic [10:0] cfg_n = 11'd3;
    logic [10:0] cfg_r = 11'd3;
    logic        fb_pulse, ref_pulse, n_clamp, a_bad, r_clamp;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pswallow_fbdiv dut (
        .clk_i             (clk),
        .rst_i             (rst),
        .swallow_i         (cfg_a),
        .main_i            (cfg_n),
        .ref_i             (cfg_r),
        .fb_pulse_o        (fb_pulse),
        .ref_pulse_o       (ref_pulse),
        .main_clamped_o    (n_clamp),
        .swallow_invalid_o (a_bad),
        .ref_clamped_o     (r_clamp)
    );

    typedef struct packed {
        int a; int n; int r; int t; int rp; int nc; int ab; int rc;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{a:0,  n:3,  r:3,    t:96,   rp:3,    nc:0, ab:0, rc:0},
        '{a:1,  n:3,  r:5,    t:97,   rp:5,    nc:0, ab:0, rc:0},
        '{a:5,  n:10, r:100,  t:325,  rp:100,  nc:0, ab:0, rc:0},
        '{a:31, n:40, r:2047, t:1311, rp:2047, nc:0, ab:0, rc:0},
        '{a:3,  n:3,  r:4,    t:99,   rp:4,    nc:0, ab:0, rc:0},
        '{a:0,  n:2,  r:0,    t:96,   rp:3,    nc:1, ab:0, rc:1},
        '{a:4,  n:1,  r:1,    t:99,   rp:3,    nc:1, ab:1, rc:1},
        '{a:10, n:4,  r:2,    t:132,  rp:3,    nc:0, ab:1, rc:1}
    };

    task automatic check_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input int a, input int n, input int r);
        @(negedge clk);
        rst   = 1'b1;
        cfg_a = 5'(a);
        cfg_n = 11'(n);
        cfg_r = 11'(r);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic advance(input int edges);
        for (int i = 0; i < edges; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wait_pulse(input bit use_ref, output int cnt);
        bit seen;
        cnt  = 0;
        seen = 1'b0;
        while (!seen && cnt < 70000) begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            seen = use_ref ? ref_pulse : fb_pulse;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<190000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int got;

        // R8: outputs low while reset is held
        do_reset(5, 10, 7);
        @(negedge clk);
        rst = 1'b1;
        advance(1);
        check_int("R8 fb_pulse in reset", int'(fb_pulse), 0);
        check_int("R8 ref_pulse in reset", int'(ref_pulse), 0);
        rst = 1'b0;

        // R1 R3 R4 R5 R6 R8: vector table
        foreach (VEC[i]) begin
            do_reset(VEC[i].a, VEC[i].n, VEC[i].r);
            check_int($sformatf("R3 main_clamped v%0d", i), int'(n_clamp), VEC[i].nc);
            check_int($sformatf("R4 swallow_invalid v%0d", i), int'(a_bad), VEC[i].ab);
            check_int($sformatf("R6 ref_clamped v%0d", i), int'(r_clamp), VEC[i].rc);
            wait_pulse(1'b0, got);
            check_int($sformatf("R8 first fb interval v%0d", i), got, VEC[i].t);
            wait_pulse(1'b0, got);
            check_int($sformatf("R1 fb interval v%0d", i), got, VEC[i].t);
            advance(1);
            check_int($sformatf("R2 fb pulse width v%0d", i), int'(fb_pulse), 0);
            do_reset(VEC[i].a, VEC[i].n, VEC[i].r);
            wait_pulse(1'b1, got);
            check_int($sformatf("R8 first ref interval v%0d", i), got, VEC[i].rp);
            wait_pulse(1'b1, got);
            check_int($sformatf("R5 ref interval v%0d", i), got, VEC[i].rp);
            advance(1);
            check_int($sformatf("R2 ref pulse width v%0d", i), int'(ref_pulse), 0);
        end

        // R7: feedback setting written mid-cycle
        do_reset(0, 3, 3);
        advance(50);
        cfg_a = 5'd1;
        cfg_n = 11'd4;
        wait_pulse(1'b0, got);
        check_int("R7 fb cycle in progress unchanged", got, 46);
        wait_pulse(1'b0, got);
        check_int("R7 fb new ratio after pulse", got, 129);
        check_int("R7 flags after change", int'(n_clamp) + int'(a_bad), 0);

        // R7: reference setting written mid-cycle
        do_reset(0, 3, 20);
        advance(5);
        cfg_r = 11'd7;
        wait_pulse(1'b1, got);
        check_int("R7 ref cycle in progress unchanged", got, 15);
        wait_pulse(1'b1, got);
        check_int("R7 ref new ratio after pulse", got, 7);

        // R7: clamped N written mid-cycle raises the flag only at the boundary
        do_reset(0, 3, 3);
        advance(10);
        cfg_n = 11'd0;
        check_int("R7 flag held mid-cycle", int'(n_clamp), 0);
        wait_pulse(1'b0, got);
        check_int("R3 flag after boundary", int'(n_clamp), 1);

        // R9: maximum ratio
        do_reset(31, 2047, 3);
        wait_pulse(1'b0, got);
        check_int("R9 maximum ratio", got, 65535);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule